// File: doc/BRIEF.md
# External Bus Idle-Cycle Sequencer

This block sits between an internal access request port and the chip-select and strobe pins of an external memory bus that has eight address areas. Each accepted access drives exactly one active-low chip select, together with either the read strobe or the write strobe, for one bus cycle. Between two accesses the block can insert idle bus cycles. During these cycles every chip select and both strobes stay inactive, so the end of each bus cycle is visible on the pins.

The number of idle cycles depends on the previous accepted access, which the block records as an area and a direction. Areas 2 and 6 form a pair, and areas 3 and 7 form a second pair. Each pair has one continuous-access enable bit. When a pair's bit is set, one idle cycle separates an access to a pair member from a preceding access to the same area or to its partner. A separate read-to-write field sets how many idle cycles separate a write from a preceding read. When both rules apply, the larger count wins.

A small register holds the two enable bits and the read-to-write field. Requests use a valid/ready handshake. Ready stays low while idle cycles count down.

Top module: `bus_idle_seq`

## Requirements
- R1: After reset all chip selects and both strobes are inactive (high), reqReady is 1 and regRdata reads 4'b0011.
- R2: Control register layout: bit 0 enables the area 2/6 pair, bit 1 enables the area 3/7 pair, and bits [3:2] hold the read-to-write idle count (0 to 3). A write through regWe is visible on regRdata from the next cycle.
- R3: An access that needs no idle cycle drives, in the cycle after its handshake, csN[area]=0 for one cycle with all other chip selects high. For a read (reqWrite=0) rdN is 0; for a write wrN is 0. busAddr equals the request address.
- R4: With a pair's enable bit at 1, a repeat access to the same paired area gets exactly one idle cycle. In that cycle all chip selects and strobes are high and reqReady is 0.
- R5: With a pair's enable bit at 1, an access to one member of the pair after an access to the other member gets exactly one idle cycle, in either direction.
- R6: With a pair's enable bit at 0, back-to-back accesses within that pair get no idle cycle, and the chip selects follow each other in consecutive cycles.
- R7: The enable bits never add an idle cycle when the two accesses are not in the same pair. This covers areas 2 then 3, a repeat of area 0, and areas 1 then 5.
- R8: A write after a read gets max(read-to-write field, continuous-access count) idle cycles, whatever the areas. A write after a write gets no read-to-write idle cycles.
- R9: The first access after reset never gets an idle cycle.
- R10: During idle cycles busAddr keeps the address of the previous access.
- R11: The idle count depends only on the previous accepted access. Empty bus cycles between two accesses do not reduce it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqArea | input | 3 | Target area number 0 to 7 |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | AW | Access address |
| regWe | input | 1 | Control register write enable |
| regWdata | input | IDLE_W+2 | Control register write data |
| regRdata | output | IDLE_W+2 | Control register read data |
| csN | output | 8 | Active-low chip selects, one per area |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| busAddr | output | AW | External address |

## Verification
The bench builds the block with its defaults: AW=16 and IDLE_W=2. The 2-bit read-to-write field lets the bench reach the full 0 to 3 cycle range. With that range it can set up cases where the field beats the continuous-access count, where the two are equal, and where the continuous-access count wins. The 16-bit address gives distinct values per access, so the bench can tell a held address apart from the next one during idle cycles.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;
  localparam int AREA_CNT = 8;
  localparam int AREA_W = $clog2(AREA_CNT);

  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_GAP    = 2'd1,
    ST_ACCESS = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;    // latch request as pending and as previous access
    logic launchReq;  // start bus cycle from the live request
    logic launchPend; // start bus cycle from the pending request
  } seqCtl_t;
endpackage

// File: rtl/bus_idle_ctl.sv
module bus_idle_ctl
  import bus_idle_pkg::*;
#(
  parameter int IDLE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDLE_W-1:0] idleNeed,
  output logic              reqReady,
  output seqCtl_t           ctl
);
  seqState_t state, stateNxt;
  logic [IDLE_W-1:0] gapCnt, gapCntNxt;

  always_comb begin
    ctl = '0;
    stateNxt = state;
    gapCntNxt = gapCnt;
    reqReady = (state != ST_GAP);
    case (state)
      ST_GAP: begin
        if (gapCnt == IDLE_W'(1)) begin
          ctl.launchPend = 1'b1;
          stateNxt = ST_ACCESS;
          gapCntNxt = '0;
        end else begin
          gapCntNxt = gapCnt - IDLE_W'(1);
        end
      end
      default: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          if (idleNeed == '0) begin
            ctl.launchReq = 1'b1;
            stateNxt = ST_ACCESS;
          end else begin
            stateNxt = ST_GAP;
            gapCntNxt = idleNeed;
          end
        end else begin
          stateNxt = ST_READY;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_READY;
      gapCnt <= '0;
    end else begin
      state <= stateNxt;
      gapCnt <= gapCntNxt;
    end
  end

  AST_GAP_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> (gapCnt != '0)); // R4
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.launchReq && ctl.launchPend)); // R3
  AST_GAP_ENDS_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && gapCnt == IDLE_W'(1)) |=> (state == ST_ACCESS)); // R8
endmodule

// File: rtl/bus_idle_dp.sv
module bus_idle_dp
  import bus_idle_pkg::*;
#(
  parameter int AW = 16,
  parameter int IDLE_W = 2,
  localparam int REG_W = IDLE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [IDLE_W-1:0] idleNeed,
  output logic [AREA_CNT-1:0] csN,
  output logic              rdN,
  output logic              wrN,
  output logic [AW-1:0]     busAddr
);
  logic [1:0]        contEn;
  logic [IDLE_W-1:0] rwIdle;
  logic              prevValid, prevWrite;
  logic [AREA_W-1:0] prevArea;
  logic [AREA_W-1:0] pendArea;
  logic              pendWrite;
  logic [AW-1:0]     pendAddr;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contEn <= 2'b11;
      rwIdle <= '0;
    end else if (regWe) begin
      contEn <= regWdata[1:0];
      rwIdle <= regWdata[REG_W-1:2];
    end
  end
  assign regRdata = {rwIdle, contEn};

  // previous and pending access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevArea  <= '0;
      prevWrite <= 1'b0;
      pendArea  <= '0;
      pendWrite <= 1'b0;
      pendAddr  <= '0;
    end else if (ctl.capture) begin
      prevValid <= 1'b1;
      prevArea  <= reqArea;
      prevWrite <= reqWrite;
      pendArea  <= reqArea;
      pendWrite <= reqWrite;
      pendAddr  <= reqAddr;
    end
  end

  // idle-count decision: paired areas share low bits with bit 1 set
  logic samePair, contHit, rwHit;
  logic [IDLE_W-1:0] contCnt, rwCnt;
  always_comb begin
    samePair = prevValid && reqArea[1] && (prevArea[1:0] == reqArea[1:0]);
    contHit  = samePair && contEn[reqArea[0]];
    rwHit    = prevValid && !prevWrite && reqWrite;
    contCnt  = contHit ? IDLE_W'(1) : '0;
    rwCnt    = rwHit ? rwIdle : '0;
    idleNeed = (rwCnt > contCnt) ? rwCnt : contCnt;
  end

  // output stage
  logic              launch;
  logic [AREA_W-1:0] srcArea;
  logic              srcWrite;
  logic [AW-1:0]     srcAddr;
  logic [AREA_CNT-1:0] csNxt;

  assign launch   = ctl.launchReq || ctl.launchPend;
  assign srcArea  = ctl.launchReq ? reqArea  : pendArea;
  assign srcWrite = ctl.launchReq ? reqWrite : pendWrite;
  assign srcAddr  = ctl.launchReq ? reqAddr  : pendAddr;

  for (genvar gi = 0; gi < AREA_CNT; gi++) begin : gCs
    assign csNxt[gi] = !(launch && (srcArea == AREA_W'(gi)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN     <= '1;
      rdN     <= 1'b1;
      wrN     <= 1'b1;
      busAddr <= '0;
    end else begin
      csN <= csNxt;
      rdN <= !(launch && !srcWrite);
      wrN <= !(launch && srcWrite);
      if (launch) busAddr <= srcAddr;
    end
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R3
  AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ((csN != '1) == (!rdN || !wrN))); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !launch |=> $stable(busAddr)); // R10
endmodule

// File: rtl/bus_idle_seq.sv
module bus_idle_seq
  import bus_idle_pkg::*;
#(
  parameter int AW = 16,
  parameter int IDLE_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [AREA_W-1:0]   reqArea,
  input  logic                reqWrite,
  input  logic [AW-1:0]       reqAddr,
  input  logic                regWe,
  input  logic [IDLE_W+1:0]   regWdata,
  output logic [IDLE_W+1:0]   regRdata,
  output logic [AREA_CNT-1:0] csN,
  output logic                rdN,
  output logic                wrN,
  output logic [AW-1:0]       busAddr
);
  seqCtl_t ctl;
  logic [IDLE_W-1:0] idleNeed;

  bus_idle_ctl #(.IDLE_W(IDLE_W)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .idleNeed(idleNeed),
    .reqReady(reqReady), .ctl(ctl)
  );

  bus_idle_dp #(.AW(AW), .IDLE_W(IDLE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqArea(reqArea), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .idleNeed(idleNeed), .csN(csN), .rdN(rdN), .wrN(wrN), .busAddr(busAddr)
  );

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> (csN == '1 && rdN && wrN)); // R4
  AST_NO_GAP_START: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && idleNeed == '0) |=> (csN != '1)); // R3
endmodule

// File: tb/bus_idle_seq_tb.sv
module bus_idle_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IDLE_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [2:0] reqArea = '0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic regWe = 1'b0;
  logic [IDLE_W+1:0] regWdata = '0;
  logic [IDLE_W+1:0] regRdata;
  logic [7:0] csN;
  logic rdN, wrN;
  logic [AW-1:0] busAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_idle_seq #(.AW(AW), .IDLE_W(IDLE_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqArea(reqArea), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .csN(csN), .rdN(rdN), .wrN(wrN), .busAddr(busAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkQuiet(input string req, input logic [AW-1:0] holdAddr);
    check(csN == 8'hFF, req, csN, 8'hFF);
    check(rdN && wrN, req, {rdN, wrN}, 2'b11);
    check(!reqReady, req, reqReady, 0);
    check(busAddr == holdAddr, {req, " R10 addr hold"}, busAddr, holdAddr);
  endtask

  task automatic checkAccess(input string req, input int area, input bit wr, input logic [AW-1:0] addr);
    logic [7:0] expCs;
    expCs = ~(8'b1 << area);
    check(csN == expCs, req, csN, expCs);
    check({rdN, wrN} == {!wr ? 1'b0 : 1'b1, wr ? 1'b0 : 1'b1}, req, {rdN, wrN}, {!wr ? 1'b0 : 1'b1, wr ? 1'b0 : 1'b1});
    check(busAddr == addr, req, busAddr, addr);
  endtask

  task automatic regWrite(input logic [IDLE_W+1:0] val);
    @(negedge clk);
    regWe = 1'b1; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
    check(regRdata == val, "R2 register readback", regRdata, val);
  endtask

  // leave previous access as an area-0 write so the next access has no idle
  task automatic flush();
    reqValid = 1'b1; reqArea = 3'd0; reqWrite = 1'b1; reqAddr = 16'h0F0F;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 8 && csN == 8'hFF; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic single(input string req, input int area, input bit wr, input logic [AW-1:0] addr,
                        input int expGap, input logic [AW-1:0] prevAddr);
    reqValid = 1'b1; reqArea = 3'(area); reqWrite = wr; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < expGap; i++) begin
      checkQuiet(req, prevAddr);
      @(negedge clk);
    end
    checkAccess(req, area, wr, addr);
    @(negedge clk);
  endtask

  task automatic pair(input string req, input int a1, input bit w1, input int a2, input bit w2, input int expGap);
    logic [AW-1:0] ad1, ad2;
    ad1 = 16'h1000 + 16'(a1 * 16 + a2);
    ad2 = 16'h2000 + 16'(a2 * 16 + a1);
    flush();
    reqValid = 1'b1; reqArea = 3'(a1); reqWrite = w1; reqAddr = ad1;
    @(negedge clk);
    checkAccess({req, " first"}, a1, w1, ad1);
    check(reqReady, {req, " ready in access"}, reqReady, 1);
    reqArea = 3'(a2); reqWrite = w2; reqAddr = ad2;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < expGap; i++) begin
      checkQuiet({req, " idle"}, ad1);
      @(negedge clk);
    end
    checkAccess({req, " second"}, a2, w2, ad2);
    @(negedge clk);
    check(csN == 8'hFF, {req, " end"}, csN, 8'hFF);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN == 8'hFF && rdN && wrN, "R1 outputs idle", {csN, rdN, wrN}, 10'h3FF);
    check(reqReady, "R1 ready", reqReady, 1);
    check(regRdata == 4'b0011, "R1 R2 reset register", regRdata, 4'b0011);
    rstN = 1'b1;
    @(negedge clk);
    // R9 first access after reset, to a paired area
    single("R9 first access", 2, 1'b0, 16'h0011, 0, 16'h0000);
    // R11 separate access after empty cycles still gets the idle
    repeat (4) @(negedge clk);
    single("R11 R4 separated repeat", 2, 1'b0, 16'h0022, 1, 16'h0011);
    // R4 same area
    pair("R4 area2 repeat", 2, 1'b0, 2, 1'b0, 1);
    pair("R4 area7 repeat", 7, 1'b1, 7, 1'b1, 1);
    // R5 cross pair
    pair("R5 6 to 2", 6, 1'b0, 2, 1'b0, 1);
    pair("R5 2 to 6", 2, 1'b1, 6, 1'b1, 1);
    pair("R5 3 to 7", 3, 1'b1, 7, 1'b1, 1);
    pair("R5 7 to 3", 7, 1'b0, 3, 1'b0, 1);
    // R7 not a pair
    pair("R7 2 to 3", 2, 1'b0, 3, 1'b0, 0);
    pair("R7 0 repeat", 0, 1'b0, 0, 1'b0, 0);
    pair("R7 1 to 5", 1, 1'b1, 5, 1'b1, 0);
    pair("R7 6 to 7", 6, 1'b0, 7, 1'b0, 0);
    // R6 enable bits cleared
    regWrite(4'b0000);
    pair("R6 area2 repeat", 2, 1'b0, 2, 1'b0, 0);
    pair("R6 7 to 3", 7, 1'b1, 3, 1'b1, 0);
    // R2 only pair 2/6 enabled
    regWrite(4'b0001);
    pair("R2 pair26 on", 6, 1'b0, 6, 1'b0, 1);
    pair("R2 pair37 off", 3, 1'b0, 3, 1'b0, 0);
    // R8 read-to-write field 3, pair 2/6 enabled
    regWrite(4'b1101);
    pair("R8 max rw wins same area", 2, 1'b0, 2, 1'b1, 3);
    pair("R8 max rw wins cross", 2, 1'b0, 6, 1'b1, 3);
    pair("R8 unpaired areas", 0, 1'b0, 1, 1'b1, 3);
    pair("R8 write after write", 0, 1'b1, 1, 1'b1, 0);
    pair("R8 read after read", 4, 1'b0, 5, 1'b0, 0);
    // R8 field 0: continuous count wins
    regWrite(4'b0001);
    pair("R8 cont wins", 2, 1'b0, 6, 1'b1, 1);
    pair("R8 pair off no rw", 3, 1'b0, 3, 1'b1, 0);
    // R8 equal counts
    regWrite(4'b0101);
    pair("R8 equal", 2, 1'b0, 2, 1'b1, 1);
    regWrite(4'b1011);
    pair("R8 rw2 over cont", 7, 1'b0, 3, 1'b1, 2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule